// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block puts one low-speed USB packet on the D+ and D- wires. A client pulses a start strobe together with the packet length, counted in bytes and including the sync byte. The block then presents the idle (J) level on its line outputs while the drivers are still off, and switches the drivers on one clock later. It sends the sync pattern, then asks the client for each payload byte in turn. Every bit is NRZI coded, and a stuff bit is added after every run of six ones. The packet closes with two bit times of single-ended zero and one bit time of J. The drivers are then switched off and both line outputs are left low.

Each bit lasts a whole number of clocks, set by a parameter. There is no fractional rate correction, because the low-speed rate tolerance allows it. Payload bytes are pulled through a one-cycle request pulse. The client must present the byte on `data_i` during the cycle in which `req_o` is high. A handshake reply is simply a packet of length 2: the sync byte plus one PID byte.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset and while no packet is in progress, `oe_o`, `busy_o`, `done_o` and `req_o` are low and both `dp_o` and `dm_o` are low.
- R2: A start strobe accepted while idle raises `busy_o` in the next cycle. In that cycle the lines show J (`dp_o`=0, `dm_o`=1) with `oe_o` low, and `oe_o` rises one cycle later.
- R3: The sync byte 0x80 is sent first, followed by the payload bytes in request order. Each byte goes out least-significant bit first, and every line symbol lasts exactly CLKS_PER_BIT clocks, starting in the cycle where `oe_o` rises.
- R4: The coding is NRZI. A 0 bit flips the line between J ({dp,dm}=01) and K ({dp,dm}=10), and a 1 bit holds it. `dp_o` and `dm_o` are never both high.
- R5: After six consecutive 1 bits, one extra flip (a stuff bit) is sent. The run count restarts at 0 at packet start, after every 0 bit and after every stuff bit, and it carries across byte boundaries.
- R6: When the last bit of the packet completes a run of six ones, the stuff bit is still sent before the end of packet.
- R7: After the last symbol, the lines show SE0 (both low) for 2 bit times and then J for 1 bit time, all with `oe_o` high. After that, `oe_o` drops and both lines are low.
- R8: `busy_o` stays high from the cycle after an accepted start until the lines are released. `done_o` is a one-cycle pulse in the first released cycle.
- R9: `req_o` is a one-cycle pulse, given once per payload byte (length minus 1 pulses per packet). `data_i` is taken at the clock edge that ends the pulse. The first pulse comes in the cycle right after the accepted start.
- R10: A start strobe with a length outside 2..12 is ignored. The block stays idle with its outputs as in R1.
- R11: A start strobe while `busy_o` is high is ignored. No second packet follows the one in progress.
- R12: A length of 2 sends exactly sync plus one byte, such as an ACK (0xD2) or NAK (0x5A) PID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle |
| nbytes_i | input | CNT_W | Packet length in bytes, including sync, sampled with start_i |
| data_i | input | 8 | Payload byte, valid while req_o is high |
| req_o | output | 1 | Payload byte request pulse |
| dp_o | output | 1 | D+ line level |
| dm_o | output | 1 | D- line level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Most internal faults show up on the lines within one bit time. A wrong bit index, byte source or run count changes the D+/D- level at the start of a specific symbol, and the bench compares every symbol against its own independently coded stream in the first cycle of that symbol. Faults in the bit timer or the end-of-packet counter move an edge by one or more clocks. They are caught at the next symbol start or at the SE0/J/release checkpoints. A wrong byte counter shows as a wrong number of request pulses, or as an early or late end of packet.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

    // Line levels as {dp, dm}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10
    } line_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_DATA,
        ST_SE0,
        ST_JEND
    } tx_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int         STUFF_RUN = 6;
    localparam int         RUN_W     = 3;
    localparam int         MIN_BYTES = 2;
    localparam int         SE0_BITS  = 2;

    // NRZI flip between J and K; any other level restarts from J
    function automatic line_e flip_line(input line_e l);
        line_e r;
        unique case (l)
            LN_J:    r = LN_K;
            LN_K:    r = LN_J;
            default: r = LN_J;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usb_ls_tx_timer.sv
module usb_ls_tx_timer #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int TW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [TW-1:0] LAST = TW'(CLKS_PER_BIT - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/usb_ls_tx_serial.sv
module usb_ls_tx_serial
    import usb_ls_tx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic             step_i,
    input  logic [7:0]       data_i,
    output logic             req_o,
    output logic             flip_o,
    output logic             eop_o
);
    logic [7:0]       shift_q;
    logic [7:0]       next_q;
    logic [2:0]       bidx_q;
    logic [RUN_W-1:0] ones_q;
    logic [CNT_W-1:0] left_q;
    logic             fin_q;
    logic             req_q;
    logic             stuff_now;

    assign stuff_now = (ones_q == RUN_W'(STUFF_RUN));
    assign flip_o    = stuff_now || !shift_q[0];
    assign eop_o     = fin_q && !stuff_now;
    assign req_o     = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            next_q  <= '0;
            bidx_q  <= '0;
            ones_q  <= '0;
            left_q  <= '0;
            fin_q   <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (req_q) begin
                next_q <= data_i;
            end
            if (load_i) begin
                shift_q <= SYNC_BYTE;
                bidx_q  <= '0;
                ones_q  <= '0;
                left_q  <= nbytes_i - 1'b1;
                fin_q   <= 1'b0;
                req_q   <= 1'b1;
            end else if (step_i && stuff_now) begin
                ones_q <= '0;
            end else if (step_i && !fin_q) begin
                ones_q <= shift_q[0] ? ones_q + 1'b1 : '0;
                if (bidx_q == 3'd7) begin
                    if (left_q == '0) begin
                        fin_q <= 1'b1;
                    end else begin
                        shift_q <= next_q;
                        bidx_q  <= '0;
                        left_q  <= left_q - 1'b1;
                        req_q   <= (left_q > CNT_W'(1));
                    end
                end else begin
                    shift_q <= shift_q >> 1;
                    bidx_q  <= bidx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx_ctrl.sv
module usb_ls_tx_ctrl
    import usb_ls_tx_pkg::*;
#(
    parameter int MAX_BYTES = 12,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic             tick_i,
    input  logic             flip_i,
    input  logic             eop_i,
    output logic             load_o,
    output logic             step_o,
    output logic             run_o,
    output logic             dp_o,
    output logic             dm_o,
    output logic             oe_o,
    output logic             busy_o,
    output logic             done_o
);
    tx_state_e st_q;
    line_e     line_q;
    logic      oe_q;
    logic      done_q;
    logic      se0_cnt_q;
    logic      len_ok;

    assign len_ok = (nbytes_i >= CNT_W'(MIN_BYTES)) && (nbytes_i <= CNT_W'(MAX_BYTES));
    assign load_o = (st_q == ST_IDLE) && start_i && len_ok;
    assign step_o = (st_q == ST_ARM) || ((st_q == ST_DATA) && tick_i && !eop_i);
    assign run_o  = (st_q == ST_DATA) || (st_q == ST_SE0) || (st_q == ST_JEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            line_q    <= LN_SE0;
            oe_q      <= 1'b0;
            done_q    <= 1'b0;
            se0_cnt_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (load_o) begin
                        st_q   <= ST_ARM;
                        line_q <= LN_J;
                    end
                end
                ST_ARM: begin
                    st_q   <= ST_DATA;
                    oe_q   <= 1'b1;
                    line_q <= flip_i ? flip_line(line_q) : line_q;
                end
                ST_DATA: begin
                    if (tick_i) begin
                        if (eop_i) begin
                            st_q      <= ST_SE0;
                            line_q    <= LN_SE0;
                            se0_cnt_q <= 1'b0;
                        end else if (flip_i) begin
                            line_q <= flip_line(line_q);
                        end
                    end
                end
                ST_SE0: begin
                    if (tick_i) begin
                        if (se0_cnt_q == 1'(SE0_BITS - 1)) begin
                            st_q   <= ST_JEND;
                            line_q <= LN_J;
                        end else begin
                            se0_cnt_q <= se0_cnt_q + 1'b1;
                        end
                    end
                end
                ST_JEND: begin
                    if (tick_i) begin
                        st_q   <= ST_IDLE;
                        line_q <= LN_SE0;
                        oe_q   <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign dp_o   = line_q[1];
    assign dm_o   = line_q[0];
    assign oe_o   = oe_q;
    assign busy_o = (st_q != ST_IDLE);
    assign done_o = done_q;

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int MAX_BYTES    = 12,
    parameter int CNT_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic [7:0]       data_i,
    output logic             req_o,
    output logic             dp_o,
    output logic             dm_o,
    output logic             oe_o,
    output logic             busy_o,
    output logic             done_o
);
    logic load, step, run, tick, flip, eop;

    usb_ls_tx_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    usb_ls_tx_serial #(.CNT_W(CNT_W)) u_serial (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .nbytes_i (nbytes_i),
        .step_i   (step),
        .data_i   (data_i),
        .req_o    (req_o),
        .flip_o   (flip),
        .eop_o    (eop)
    );

    usb_ls_tx_ctrl #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .nbytes_i (nbytes_i),
        .tick_i   (tick),
        .flip_i   (flip),
        .eop_i    (eop),
        .load_o   (load),
        .step_o   (step),
        .run_o    (run),
        .dp_o     (dp_o),
        .dm_o     (dm_o),
        .oe_o     (oe_o),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk (
    input logic clk,
    input logic rst,
    input logic req_o,
    input logic dp_o,
    input logic dm_o,
    input logic oe_o,
    input logic busy_o,
    input logic done_o
);
    // R1: quiet outputs whenever no packet is in progress
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!oe_o && !dp_o && !dm_o && !req_o));

    // R2: drivers switch on only out of a J level
    p_j_before_oe_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_o) |-> (!$past(dp_o) && $past(dm_o)));

    // R4: never both lines high
    p_no_se1_r4: assert property (@(posedge clk) disable iff (rst)
        !(dp_o && dm_o));

    // R7: release follows J and coincides with done
    p_release_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_o) |-> (done_o && $past(dm_o) && !$past(dp_o)));

    // R8: drivers only on while busy; done is a single pulse
    p_oe_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        oe_o |-> busy_o);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: request is a single-cycle pulse
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

endmodule

bind usb_ls_tx usb_ls_tx_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_o  (req_o),
    .dp_o   (dp_o),
    .dm_o   (dm_o),
    .oe_o   (oe_o),
    .busy_o (busy_o),
    .done_o (done_o)
);

// File: tb/usb_ls_tx_bench.sv
`timescale 1ns/1ps
module usb_ls_tx_bench;
    localparam int N     = 8;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] nbytes_i = '0;
    logic [7:0]       data_i;
    logic             req_o, dp_o, dm_o, oe_o, busy_o, done_o;

    logic [7:0] pay [0:15];
    logic [1:0] exp_sym [0:159];
    int         nsym;
    int         idx = 0;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    assign data_i = pay[idx];

    usb_ls_tx #(.CLKS_PER_BIT(N), .MAX_BYTES(12)) u_usb_ls_tx (
        .clk(clk), .rst(rst), .start_i(start_i), .nbytes_i(nbytes_i),
        .data_i(data_i), .req_o(req_o), .dp_o(dp_o), .dm_o(dm_o),
        .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o)
    );

    // byte source: advances on each request, restarts on an idle start
    initial begin
        forever begin
            @(posedge clk);
            if (start_i && !busy_o) idx <= 0;
            else if (req_o) idx <= idx + 1;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // independent NRZI + stuffing model of the expected line stream
    task automatic build(input int n);
        logic [1:0] ln;
        int ones;
        logic [7:0] v;
        ln = 2'b01; ones = 0; nsym = 0;
        for (int j = 0; j < n; j++) begin
            v = (j == 0) ? 8'h80 : pay[j-1];
            for (int i = 0; i < 8; i++) begin
                if (v[i]) ones++;
                else begin ln = ~ln; ones = 0; end
                exp_sym[nsym] = ln; nsym++;
                if (ones == 6) begin
                    ln = ~ln; ones = 0;
                    exp_sym[nsym] = ln; nsym++;
                end
            end
        end
    endtask

    task automatic send_pkt(input int n, input string tag, input bit poke);
        build(n);
        @(negedge clk);
        nbytes_i = CNT_W'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "busy after start", busy_o, 1);
        check("R2", "oe off while presetting", oe_o, 0);
        check("R2", "preset J", {dp_o, dm_o}, 2'b01);
        @(negedge clk);
        check("R2", "oe on", oe_o, 1);
        for (int k = 0; k < nsym; k++) begin
            check(tag, $sformatf("symbol %0d", k), {dp_o, dm_o}, exp_sym[k]);
            if (poke && k == 2) begin
                nbytes_i = 4'd2; start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                repeat (N - 1) @(negedge clk);
            end else begin
                repeat (N) @(negedge clk);
            end
        end
        check("R7", "SE0 first bit", {oe_o, dp_o, dm_o}, 3'b100);
        repeat (N) @(negedge clk);
        check("R7", "SE0 second bit", {oe_o, dp_o, dm_o}, 3'b100);
        repeat (N) @(negedge clk);
        check("R7", "closing J", {oe_o, dp_o, dm_o}, 3'b101);
        repeat (N) @(negedge clk);
        check("R7", "released", {oe_o, dp_o, dm_o}, 3'b000);
        check("R8", "done pulse", done_o, 1);
        check("R8", "busy cleared", busy_o, 0);
        check("R9", "request count", idx, n - 1);
        @(negedge clk);
        check("R8", "done single cycle", done_o, 0);
        check(poke ? "R11" : "R8", "stays idle", busy_o, 0);
        repeat (3) @(negedge clk);
        check(poke ? "R11" : "R1", "no new packet", {busy_o, oe_o}, 2'b00);
    endtask

    task automatic t_reset();
        check("R1", "idle outputs", {oe_o, busy_o, done_o, req_o, dp_o, dm_o}, 6'b0);
    endtask

    task automatic t_handshake();
        pay[0] = 8'hD2; send_pkt(2, "R12", 1'b0);
        pay[0] = 8'h5A; send_pkt(2, "R12", 1'b0);
    endtask

    task automatic t_plain();
        pay[0] = 8'hC3; pay[1] = 8'h55; pay[2] = 8'h0E;
        send_pkt(4, "R3", 1'b0);
    endtask

    task automatic t_stuff_span();
        pay[0] = 8'hF0; pay[1] = 8'h03; pay[2] = 8'hFF; pay[3] = 8'h7E;
        send_pkt(5, "R5", 1'b0);
    endtask

    task automatic t_stuff_last();
        pay[0] = 8'hFC; send_pkt(2, "R6", 1'b0);
    endtask

    task automatic t_max();
        for (int j = 0; j < 11; j++) pay[j] = 8'(j * 37 + 5);
        send_pkt(12, "R4", 1'b0);
    endtask

    task automatic t_busy_start();
        pay[0] = 8'hA5; send_pkt(2, "R11", 1'b1);
    endtask

    task automatic t_bad_len(input int n);
        @(negedge clk);
        nbytes_i = CNT_W'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10", $sformatf("len %0d ignored", n), {busy_o, oe_o, dp_o, dm_o, req_o}, 5'b0);
        repeat (3) @(negedge clk);
        check("R10", $sformatf("len %0d still idle", n), {busy_o, oe_o, dp_o, dm_o, req_o}, 5'b0);
    endtask

    initial begin
        for (int j = 0; j < 16; j++) pay[j] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_plain();
        t_stuff_span();
        t_stuff_last();
        t_max();
        t_busy_start();
        t_bad_len(1);
        t_bad_len(13);
        t_bad_len(0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule